// File: doc/BRIEF.md
# DMA Channel Trigger Control

This block is the control slice of one DMA channel. It decides, cycle by cycle, whether the channel's data mover may move a beat. A 32-bit control word sits behind a plain write port and can be read back. It chooses one peripheral request line as the channel's trigger. It sets how much work a single trigger unlocks: one beat, one block, or a whole transaction. The word also sets the channel's priority level for an arbiter outside the block, and how incoming events act on the channel.

The channel can be suspended and resumed in three ways: by a one-shot command field in the word, by an incoming event, or automatically when a block ends and the descriptor asks for it. An event can also arm a one-shot flag that cancels the next block-end suspension. Triggers that arrive while the channel cannot use them are held as a single pending request.

Top module: `dma_trig_ctrl`

## Requirements
- R1: After reset the control word reads as zero, `beat_grant` is low, `suspended` is low and `prio_lvl` is 0.
- R2: The word packs its fields as follows, and every other bit reads as 0:
  - command in bits 25:24
  - trigger mode in bits 23:22
  - source in bits 15:8
  - level in bits 7:5
  - event-output enable in bit 4
  - event-input enable in bit 3
  - event action in bits 2:0

  While `chan_en` is high, a write changes only the command field.
- R3: A write that carries a reserved code leaves that field at its previous value. The reserved codes are trigger mode 1, command 3, a source above NUM_SRC, a level above 3, and event action 7.
- R4: A command written into the word takes effect on the next clock edge and then reads back as 0. Command 1 suspends the channel and command 2 resumes it.
- R5: Source 0 selects no peripheral line. Source k (1..NUM_SRC) selects `periph_req[k-1]`. `sw_trig` is a trigger whatever the source.
- R6: In beat mode (mode 2), each accepted trigger gives exactly one `beat_grant` cycle, one cycle after it is sampled. A trigger that cannot be accepted is held as one pending request, and further ones are merged into it.
- R7: In block mode (mode 0), a trigger opens a window in which `beat_grant` is high every cycle until `blk_done` is sampled. In transaction mode (mode 3) the window closes only on `xfer_done`. A trigger that arrives while a window is open is held and reopens the window after it closes.
- R8: `evt_in` has no effect while event-input enable is 0. With the enable set, the event actions work as follows:
  - action 1 acts as a trigger
  - action 4 suspends the channel
  - action 5 resumes the channel
- R9: With the enable set, event actions 2 and 3 work as follows:
  - Action 2 makes a selected peripheral request count only in a cycle that also carries an event.
  - Action 3 makes an event a trigger only when no window is open and nothing is pending; otherwise the event is dropped.
- R10: `blk_done` with `blk_end_susp` high suspends the channel. Event action 6 arms a flag that cancels the next such suspension, and the flag then clears.
- R11: While suspended, `beat_grant` stays low and triggers are held. A resume in the same cycle as any suspend request wins.
- R12: While `chan_en` is low, `beat_grant` is low and open windows and pending requests are discarded. `prio_lvl` always shows the stored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enabled; locks all fields except the command |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| periph_req | input | NUM_SRC | Peripheral trigger request lines |
| sw_trig | input | 1 | Software trigger strobe |
| evt_in | input | 1 | Incoming event strobe |
| blk_done | input | 1 | Data mover finished a block |
| xfer_done | input | 1 | Data mover finished the transaction |
| blk_end_susp | input | 1 | Current descriptor asks for suspension at block end |
| beat_grant | output | 1 | Permission for one beat in this cycle |
| suspended | output | 1 | Channel is suspended |
| prio_lvl | output | 2 | Arbitration level, higher wins |

## Verification
The bench builds the block with NUM_SRC = 4. This puts the first reserved source code at 5, so the R3 source boundary can be reached with a short request bus. It also leaves an unselected line next to the selected one, so the R5 check can show that the wrong line is ignored. A behavioural model tracks the pending request, the window, the suspend state and the skip flag, and compares its results with the block's outputs on every cycle. The sequence steers the channel through beat, block and transaction modes and through each event action. It also covers command self-clearing and a resume that arrives together with a suspend.

// File: rtl/dma_trig_pkg.sv
`timescale 1ns/1ps
package dma_trig_pkg;
  localparam int WORD_W = 32;
  localparam int SRC_W  = 8;
  localparam int LVL_W  = 3;
  localparam int LVL_MAX = 3;

  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_SUSP = 2'd1, CMD_RES = 2'd2, CMD_RSVD = 2'd3} cmd_e;
  typedef enum logic [1:0] {TA_BLOCK = 2'd0, TA_RSVD = 2'd1, TA_BEAT = 2'd2, TA_XACT = 2'd3} act_e;
  typedef enum logic [2:0] {EV_NONE = 3'd0, EV_TRIG = 3'd1, EV_CTRIG = 3'd2, EV_CBLK = 3'd3,
                            EV_SUSP = 3'd4, EV_RES = 3'd5, EV_SKIP = 3'd6, EV_RSVD = 3'd7} eva_e;

  typedef struct packed {
    cmd_e             cmd;
    act_e             act;
    logic [SRC_W-1:0] src;
    logic [LVL_W-1:0] lvl;
    logic             evo;
    logic             evi;
    eva_e             eva;
  } cfg_t;

  function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.cmd = cmd_e'(w[25:24]);
    c.act = act_e'(w[23:22]);
    c.src = w[15:8];
    c.lvl = w[7:5];
    c.evo = w[4];
    c.evi = w[3];
    c.eva = eva_e'(w[2:0]);
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[25:24] = c.cmd;
    w[23:22] = c.act;
    w[15:8]  = c.src;
    w[7:5]   = c.lvl;
    w[4]     = c.evo;
    w[3]     = c.evi;
    w[2:0]   = c.eva;
    return w;
  endfunction

  function automatic logic src_ok(input logic [SRC_W-1:0] s, input int n);
    return int'(s) <= n;
  endfunction

  function automatic logic lvl_ok(input logic [LVL_W-1:0] l);
    return int'(l) <= LVL_MAX;
  endfunction

  // one pending slot: a taken grant consumes it, a fresh trigger refills it
  function automatic logic pend_next(input logic held, input logic fresh, input logic taken);
    return taken ? (held && fresh) : (held || fresh);
  endfunction
endpackage

// File: rtl/dma_trig_cfg.sv
`timescale 1ns/1ps
module dma_trig_cfg import dma_trig_pkg::*; #(
  parameter int NUM_SRC = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output cfg_t              cfg,
  output logic [WORD_W-1:0] rd_data
);
  cfg_t cfg_q, cfg_d, wr_f;

  assign wr_f = word_to_cfg(wr_data);

  always_comb begin
    cfg_d     = cfg_q;
    cfg_d.cmd = (wr_en && wr_f.cmd != CMD_RSVD) ? wr_f.cmd : CMD_NONE;
    if (wr_en && !chan_en) begin
      if (wr_f.act != TA_RSVD)        cfg_d.act = wr_f.act;
      if (src_ok(wr_f.src, NUM_SRC))  cfg_d.src = wr_f.src;
      if (lvl_ok(wr_f.lvl))           cfg_d.lvl = wr_f.lvl;
      if (wr_f.eva != EV_RSVD)        cfg_d.eva = wr_f.eva;
      cfg_d.evo = wr_f.evo;
      cfg_d.evi = wr_f.evi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg     = cfg_q;
  assign rd_data = cfg_to_word(cfg_q);

  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en |=> ($stable(cfg_q.act) && $stable(cfg_q.src) && $stable(cfg_q.lvl) && $stable(cfg_q.eva))); // R2
  AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.act != TA_RSVD); // R3
  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cfg_q.src) <= NUM_SRC); // R3
  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.cmd != CMD_NONE && !wr_en) |=> cfg_q.cmd == CMD_NONE); // R4
endmodule

// File: rtl/dma_trig_sel.sv
`timescale 1ns/1ps
module dma_trig_sel import dma_trig_pkg::*; #(
  parameter int NUM_SRC = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cfg_t               cfg,
  input  logic [NUM_SRC-1:0] periph_req,
  input  logic               sw_trig,
  input  logic               evt_in,
  input  logic               busy,
  output logic               trig,
  output logic               ev_susp,
  output logic               ev_res,
  output logic               ev_skip
);
  logic [NUM_SRC-1:0] line_hit;
  logic periph_hit, ev_live, gate_on_evt, periph_trig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
    assign line_hit[g] = periph_req[g] && (cfg.src == SRC_W'(g + 1));
  end
  assign periph_hit = |line_hit;

  assign ev_live     = evt_in && cfg.evi;
  assign gate_on_evt = cfg.evi && (cfg.eva == EV_CTRIG);
  assign periph_trig = gate_on_evt ? (ev_live && periph_hit) : periph_hit;

  assign trig = sw_trig || periph_trig
             || (ev_live && cfg.eva == EV_TRIG)
             || (ev_live && cfg.eva == EV_CBLK && !busy);
  assign ev_susp = ev_live && (cfg.eva == EV_SUSP);
  assign ev_res  = ev_live && (cfg.eva == EV_RES);
  assign ev_skip = ev_live && (cfg.eva == EV_SKIP);

  AST_EVT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.evi |-> !(ev_susp || ev_res || ev_skip)); // R8
  AST_SRC0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.src == '0 && !sw_trig && !evt_in) |-> !trig); // R5
endmodule

// File: rtl/dma_trig_seq.sv
`timescale 1ns/1ps
module dma_trig_seq import dma_trig_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  act_e act,
  input  cmd_e cmd,
  input  logic trig,
  input  logic ev_susp,
  input  logic ev_res,
  input  logic ev_skip,
  input  logic blk_done,
  input  logic xfer_done,
  input  logic blk_end_susp,
  output logic beat_grant,
  output logic suspended,
  output logic busy
);
  logic susp_q, skip_q, pend_q, win_q, tok_q;
  logic beat_mode, done_sel, take, blk_end, sus_set, res_req;

  assign beat_mode = (act == TA_BEAT);
  assign done_sel  = (act == TA_XACT) ? xfer_done : blk_done;
  assign take      = chan_en && !susp_q && (pend_q || trig) && (beat_mode || !win_q);
  assign blk_end   = chan_en && blk_done && blk_end_susp;
  assign sus_set   = (cmd == CMD_SUSP) || ev_susp || (blk_end && !skip_q);
  assign res_req   = (cmd == CMD_RES) || ev_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      skip_q <= 1'b0;
      pend_q <= 1'b0;
      win_q  <= 1'b0;
      tok_q  <= 1'b0;
    end else begin
      susp_q <= res_req ? 1'b0 : (sus_set ? 1'b1 : susp_q);
      skip_q <= ev_skip ? 1'b1 : ((blk_end && skip_q) ? 1'b0 : skip_q);
      if (!chan_en) begin
        pend_q <= 1'b0;
        win_q  <= 1'b0;
        tok_q  <= 1'b0;
      end else begin
        pend_q <= pend_next(pend_q, trig, take);
        tok_q  <= take && beat_mode;
        if (win_q && done_sel)        win_q <= 1'b0;
        else if (take && !beat_mode)  win_q <= 1'b1;
      end
    end
  end

  assign beat_grant = chan_en && !susp_q && (tok_q || win_q);
  assign suspended  = susp_q;
  assign busy       = win_q || pend_q;

  AST_SUSP_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SUSP && !ev_res) |=> suspended); // R4
  AST_RESUME_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    res_req |=> !suspended); // R11
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!win_q && !pend_q && !tok_q)); // R12
  AST_SKIP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && skip_q && !ev_skip) |=> !skip_q); // R10
  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_end && skip_q && cmd == CMD_NONE && !ev_susp && !res_req) |=> suspended == $past(suspended)); // R10
endmodule

// File: rtl/dma_trig_ctrl.sv
`timescale 1ns/1ps
module dma_trig_ctrl import dma_trig_pkg::*; #(
  parameter int NUM_SRC = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] periph_req,
  input  logic               sw_trig,
  input  logic               evt_in,
  input  logic               blk_done,
  input  logic               xfer_done,
  input  logic               blk_end_susp,
  output logic               beat_grant,
  output logic               suspended,
  output logic [1:0]         prio_lvl
);
  cfg_t cfg;
  logic trig, ev_susp, ev_res, ev_skip, busy;

  dma_trig_cfg #(.NUM_SRC(NUM_SRC)) i_cfg (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en),
    .wr_data(wr_data), .cfg(cfg), .rd_data(rd_data)
  );

  dma_trig_sel #(.NUM_SRC(NUM_SRC)) i_sel (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .periph_req(periph_req),
    .sw_trig(sw_trig), .evt_in(evt_in), .busy(busy), .trig(trig),
    .ev_susp(ev_susp), .ev_res(ev_res), .ev_skip(ev_skip)
  );

  dma_trig_seq i_seq (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .act(cfg.act), .cmd(cfg.cmd),
    .trig(trig), .ev_susp(ev_susp), .ev_res(ev_res), .ev_skip(ev_skip),
    .blk_done(blk_done), .xfer_done(xfer_done), .blk_end_susp(blk_end_susp),
    .beat_grant(beat_grant), .suspended(suspended), .busy(busy)
  );

  assign prio_lvl = cfg.lvl[1:0];

  AST_LVL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_ok(cfg.lvl)); // R3
  AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !beat_grant); // R12
endmodule

// File: tb/test_dma_trig_ctrl.sv
`timescale 1ns/1ps
module test_dma_trig_ctrl;
  localparam int NSRC = 4;

  logic clk = 1'b0, rst_n = 1'b0, chan_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NSRC-1:0] periph_req = '0;
  logic sw_trig = 1'b0, evt_in = 1'b0, blk_done = 1'b0, xfer_done = 1'b0, blk_end_susp = 1'b0;
  logic beat_grant, suspended;
  logic [1:0] prio_lvl;

  int checks = 0, failures = 0, gcnt = 0;

  dma_trig_ctrl #(.NUM_SRC(NSRC)) i_dma_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .periph_req(periph_req), .sw_trig(sw_trig), .evt_in(evt_in),
    .blk_done(blk_done), .xfer_done(xfer_done), .blk_end_susp(blk_end_susp),
    .beat_grant(beat_grant), .suspended(suspended), .prio_lvl(prio_lvl)
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_cmd, m_act, m_src, m_lvl, m_evo, m_evi, m_eva, m_pend, avail, nc;
  bit m_susp, m_skip, m_win, m_tok;
  bit hit, evl, ptrig, trg, bend, go_s, go_r, can, dn, old_susp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = 0; m_act = 0; m_src = 0; m_lvl = 0; m_evo = 0; m_evi = 0; m_eva = 0;
      m_pend = 0; m_susp = 0; m_skip = 0; m_win = 0; m_tok = 0;
    end else begin
      hit = 0;
      if (m_src > 0 && m_src <= NSRC) hit = periph_req[m_src-1];
      evl = evt_in && (m_evi != 0);
      if (m_evi != 0 && m_eva == 2) ptrig = evl && hit; else ptrig = hit;
      trg = sw_trig || ptrig || (evl && m_eva == 1) || (evl && m_eva == 3 && !m_win && m_pend == 0);
      bend = chan_en && blk_done && blk_end_susp;
      go_s = (m_cmd == 1) || (evl && m_eva == 4) || (bend && !m_skip);
      go_r = (m_cmd == 2) || (evl && m_eva == 5);
      old_susp = m_susp;
      // window and pending (R6, R7, R11, R12)
      if (!chan_en) begin
        m_pend = 0; m_win = 0; m_tok = 0;
      end else begin
        avail = m_pend + (trg ? 1 : 0);
        can = !old_susp && avail > 0 && (m_act == 2 || !m_win);
        if (can) avail = avail - 1;
        m_pend = (avail > 0) ? 1 : 0;
        m_tok = can && (m_act == 2);
        dn = (m_act == 3) ? xfer_done : blk_done;
        if (m_win && dn) m_win = 0;
        else if (can && m_act != 2) m_win = 1;
      end
      // suspend and skip (R4, R8, R10, R11)
      if (bend) m_skip = 0;
      if (evl && m_eva == 6) m_skip = 1;
      if (go_r) m_susp = 0; else if (go_s) m_susp = 1;
      // register (R2, R3)
      nc = int'(wr_data[25:24]);
      m_cmd = (wr_en && nc != 3) ? nc : 0;
      if (wr_en && !chan_en) begin
        if (wr_data[23:22] != 2'd1) m_act = int'(wr_data[23:22]);
        if (int'(wr_data[15:8]) <= NSRC) m_src = int'(wr_data[15:8]);
        if (int'(wr_data[7:5]) <= 3) m_lvl = int'(wr_data[7:5]);
        if (wr_data[2:0] != 3'd7) m_eva = int'(wr_data[2:0]);
        m_evo = int'(wr_data[4]);
        m_evi = int'(wr_data[3]);
      end
    end
  end

  function automatic logic [31:0] mk(int cmd, int act, int src, int lvl, int evo, int evi, int eva);
    return (32'(cmd) << 24) | (32'(act) << 22) | (32'(src) << 8) | (32'(lvl) << 5)
         | (32'(evo) << 4) | (32'(evi) << 3) | 32'(eva);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (beat_grant) gcnt++;
      chk("R6 R7 R11 R12 grant", 32'(beat_grant), 32'(chan_en && !m_susp && (m_tok || m_win)));
      chk("R4 R8 R10 R11 suspended", 32'(suspended), 32'(m_susp));
      chk("R12 prio_lvl", 32'(prio_lvl), 32'(m_lvl));
      chk("R2 R3 rd_data", rd_data, mk(m_cmd, m_act, m_src, m_lvl, m_evo, m_evi, m_eva));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic reconf(input logic [31:0] d);
    chan_en = 1'b0; step(); wr(d); chan_en = 1'b1; step();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  logic [31:0] w1;
  initial begin
    repeat (3) step();
    rst_n = 1'b1; step();
    // R1 reset state
    chk("R1 word", rd_data, 32'h0);
    chk("R1 grant", 32'(beat_grant), 32'h0);
    chk("R1 suspended", 32'(suspended), 32'h0);
    chk("R1 prio", 32'(prio_lvl), 32'h0);

    // R2 layout
    w1 = mk(0, 2, 2, 3, 1, 1, 1);
    wr(w1);
    chk("R2 readback", rd_data, w1);
    // R3 reserved codes everywhere, unused bits set
    wr(mk(3, 1, 9, 5, 1, 1, 7) | 32'hFC3F_0000);
    chk("R3 reserved kept", rd_data, w1);
    chk("R12 prio shows level", 32'(prio_lvl), 32'd3);

    chan_en = 1'b1; step();
    wr(mk(0, 0, 3, 1, 0, 0, 4));
    chk("R2 locked while enabled", rd_data, w1);

    // R6 single beat per trigger
    gcnt = 0; periph_req[1] = 1'b1; step(); periph_req = '0; repeat (4) step();
    chk("R6 one beat", 32'(gcnt), 32'd1);
    gcnt = 0; periph_req[1] = 1'b1; repeat (3) step(); periph_req = '0; repeat (3) step();
    chk("R6 three beats", 32'(gcnt), 32'd3);
    // R5 unselected line ignored, sw trigger always counts
    gcnt = 0; periph_req[0] = 1'b1; periph_req[2] = 1'b1; step(); periph_req = '0; repeat (3) step();
    chk("R5 other line ignored", 32'(gcnt), 32'd0);
    gcnt = 0; sw_trig = 1'b1; step(); sw_trig = 1'b0; repeat (3) step();
    chk("R5 software trigger", 32'(gcnt), 32'd1);

    // R4 software suspend with self-clear
    wr(mk(1, 0, 0, 0, 0, 0, 0));
    chk("R4 cmd stored", 32'(rd_data[25:24]), 32'd1);
    step();
    chk("R4 suspended", 32'(suspended), 32'd1);
    chk("R4 cmd cleared", 32'(rd_data[25:24]), 32'd0);
    // R11 triggers held while suspended, merged into one
    gcnt = 0; periph_req[1] = 1'b1; step(); periph_req = '0; step();
    sw_trig = 1'b1; step(); sw_trig = 1'b0; repeat (3) step();
    chk("R11 no grant suspended", 32'(gcnt), 32'd0);
    wr(mk(2, 0, 0, 0, 0, 0, 0)); repeat (4) step();
    chk("R6 held request one beat", 32'(gcnt), 32'd1);
    chk("R4 resumed", 32'(suspended), 32'd0);
    // R8 event trigger
    gcnt = 0; evt_in = 1'b1; step(); evt_in = 1'b0; repeat (3) step();
    chk("R8 event trigger", 32'(gcnt), 32'd1);

    // R8 enable gate and suspend/resume actions
    reconf(mk(0, 2, 2, 0, 0, 0, 4));
    evt_in = 1'b1; step(); evt_in = 1'b0; step();
    chk("R8 event ignored", 32'(suspended), 32'd0);
    reconf(mk(0, 2, 2, 0, 0, 1, 4));
    evt_in = 1'b1; step(); evt_in = 1'b0; step();
    chk("R8 event suspend", 32'(suspended), 32'd1);
    // R11 resume beats simultaneous suspend
    wr(mk(2, 0, 0, 0, 0, 0, 0));
    evt_in = 1'b1; step(); evt_in = 1'b0; step();
    chk("R11 resume wins", 32'(suspended), 32'd0);
    evt_in = 1'b1; step(); evt_in = 1'b0;
    reconf(mk(0, 2, 2, 0, 0, 1, 5));
    evt_in = 1'b1; step(); evt_in = 1'b0; step();
    chk("R8 event resume", 32'(suspended), 32'd0);

    // R7 block window
    reconf(mk(0, 0, 2, 2, 0, 1, 6));
    gcnt = 0; sw_trig = 1'b1; step(); sw_trig = 1'b0; step(); step();
    blk_done = 1'b1; step(); blk_done = 1'b0; repeat (3) step();
    chk("R7 block window beats", 32'(gcnt), 32'd3);
    // R7 trigger during open window reopens it
    sw_trig = 1'b1; step(); step(); sw_trig = 1'b0;
    blk_done = 1'b1; step(); blk_done = 1'b0; step();
    chk("R7 pending reopens", 32'(beat_grant), 32'd1);
    blk_done = 1'b1; step(); blk_done = 1'b0; step();
    // R10 skip cancels one block-end suspend
    evt_in = 1'b1; step(); evt_in = 1'b0;
    blk_end_susp = 1'b1;
    sw_trig = 1'b1; step(); sw_trig = 1'b0; blk_done = 1'b1; step(); blk_done = 1'b0; step();
    chk("R10 skip cancels", 32'(suspended), 32'd0);
    sw_trig = 1'b1; step(); sw_trig = 1'b0; blk_done = 1'b1; step(); blk_done = 1'b0; step();
    chk("R10 next block-end suspends", 32'(suspended), 32'd1);
    blk_end_susp = 1'b0;
    wr(mk(2, 0, 0, 0, 0, 0, 0)); step();
    step();

    // R7 transaction window ignores block ends
    reconf(mk(0, 3, 2, 1, 0, 0, 0));
    sw_trig = 1'b1; step(); sw_trig = 1'b0;
    blk_done = 1'b1; step(); blk_done = 1'b0; step();
    chk("R7 transaction stays open", 32'(beat_grant), 32'd1);
    xfer_done = 1'b1; step(); xfer_done = 1'b0; step();
    chk("R7 transaction closed", 32'(beat_grant), 32'd0);

    // R9 conditional trigger
    reconf(mk(0, 2, 2, 0, 0, 1, 2));
    gcnt = 0; periph_req[1] = 1'b1; step(); periph_req = '0; repeat (3) step();
    chk("R9 request alone gated", 32'(gcnt), 32'd0);
    periph_req[1] = 1'b1; evt_in = 1'b1; step(); periph_req = '0; evt_in = 1'b0; repeat (3) step();
    chk("R9 request with event", 32'(gcnt), 32'd1);
    // R9 conditional block: event dropped while window open
    reconf(mk(0, 0, 0, 0, 0, 1, 3));
    evt_in = 1'b1; step(); evt_in = 1'b0; step();
    evt_in = 1'b1; step(); evt_in = 1'b0; step();
    blk_done = 1'b1; step(); blk_done = 1'b0; repeat (3) step();
    chk("R9 cblock dropped", 32'(beat_grant), 32'd0);

    // R12 disable discards an open window
    sw_trig = 1'b1; step(); sw_trig = 1'b0; step();
    chan_en = 1'b0; step();
    chk("R12 off no grant", 32'(beat_grant), 32'd0);
    chan_en = 1'b1; repeat (2) step();
    chk("R12 window discarded", 32'(beat_grant), 32'd0);

    repeat (3) step();
    report();
  end
endmodule